// File: doc/BRIEF.md
# Dual-Channel Serial Controller Register Front End

This block is the processor-facing side of a two-channel asynchronous serial controller. A CPU reaches each channel through one control port and one data port. Control accesses are steered by a register pointer: a write to control register 0 loads the pointer, and may also issue a command. The next control access then reaches the selected write register (1 to 7) or read register (0 to 2). After that access the pointer falls back to 0. Data-port writes hand a byte to the external transmitter. Data-port reads take a byte from the external receiver.

The block holds the configuration bits that an external transmitter and receiver need: enables, character lengths, a raw format byte, modem outputs and automatic gating by the CTS/DCD inputs. It takes the per-channel status from those units and merges it into one interrupt request. During an interrupt-acknowledge cycle it returns an interrupt vector. When status-affects-vector is set, three bits of that vector are replaced by a code that names the highest-priority pending cause.

Top module: `ser_regif_top`

## Requirements
- R1: After reset every configuration register is 0, so all enables, RTS, DTR, lengths and format bits are 0 and `int_req` is 0.
- R2: A control write while the pointer is 0 loads the pointer from bits 2:0. The next control access reaches the selected register. After any control access with a nonzero pointer, the pointer returns to 0.
- R3: Write register 2 exists only on channel B. On channel A, a write through pointer 2 has no effect and read pointer 2 returns 0. Write registers 6 and 7 store nothing on either channel.
- R4: A register-0 write with command bits 5:3 = 3'b011 clears every register, the pointer and the external/status latch of that channel only.
- R5: Write register 5 holds RTS on bit 1, transmit enable on bit 3, transmit length on bits 6:5 and DTR on bit 7. `tx_go` = bit 3 AND (auto-enable off OR `cts`).
- R6: Write register 3 holds receive enable on bit 0, auto-enable on bit 5 and receive length on bits 7:6. `rx_go` = bit 0 AND (auto-enable off OR `dcd`). Write register 4 is presented unchanged on `fmt`.
- R7: Read register 0 returns receive-available (bit 0), interrupt pending (bit 1, channel A only), transmit-empty (bit 2), DCD (bit 3), CTS (bit 5) and break (bit 7). Read register 1 returns parity (bit 4), overrun (bit 5) and framing (bit 6). These come from `rx_err` bits 0, 1 and 2 of the channel.
- R8: While write register 1 bit 0 is set, any change of DCD, CTS or break latches an external/status interrupt. The latch holds until a register-0 command 3'b010 clears it.
- R9: In write register 1, a nonzero receive mode (bits 4:3) enables the receive-available and special-receive causes. Bit 1 enables the transmit-empty cause. `int_req` is high while any enabled cause is pending.
- R10: The vector base is channel B's write register 2. If channel B's write register 1 bit 2 is set, vector bits 3:1 are replaced by {channel is A, cause}. The cause codes are transmit empty 0, external/status 1, receive available 2 and special receive 3. With nothing pending the code is 3'b011.
- R11: Priority runs special receive, receive available, external/status, transmit empty, with every channel A cause above every channel B cause.
- R12: While `int_ack` is high, `rdata` carries the vector and no access reaches a register or the data path.
- R13: A data-port write pulses `tx_load` for the selected channel with `tx_byte` = `wdata`. A data-port read returns that channel's `rx_byte` and pulses its `rx_take`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_sel | input | 1 | Channel select, 0 = A, 1 = B |
| ctl_sel | input | 1 | 1 = control port, 0 = data port |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| int_ack | input | 1 | Interrupt acknowledge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data / vector |
| int_req | output | 1 | Interrupt request |
| tx_byte | output | 8 | Byte for the transmitter |
| tx_load | output | 2 | Per-channel transmit load pulse |
| rx_byte | input | 16 | Received byte per channel (A in 7:0) |
| rx_take | output | 2 | Per-channel receive take pulse |
| rx_avail | input | 2 | Receive character available |
| tx_empty | input | 2 | Transmit buffer empty |
| rx_err | input | 6 | Parity/overrun/framing, 3 per channel |
| cts | input | 2 | CTS input per channel |
| dcd | input | 2 | DCD input per channel |
| brk | input | 2 | Break detected per channel |
| rx_go | output | 2 | Gated receive enable |
| tx_go | output | 2 | Gated transmit enable |
| rts | output | 2 | RTS output |
| dtr | output | 2 | DTR output |
| rx_len | output | 4 | Receive length, 2 bits per channel |
| tx_len | output | 4 | Transmit length, 2 bits per channel |
| fmt | output | 16 | Format byte per channel |

## Verification
The bench builds the block with its package defaults: two channels, 8-bit data and the cause code at vector bit 1. With those values every one of the eight priority slots can be reached by raising status inputs one at a time, and each slot yields a distinct vector over a 0x40 base. The absent-register rules for channel A show up at the ports as reads of 0 and unchanged outputs. A pointer held across an acknowledge cycle can be seen because the following write still lands in write register 5.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int CH_N    = 2;
  localparam int DW      = 8;
  localparam int PTR_W   = 3;
  localparam int ERR_W   = 3;
  localparam int CAUSE_N = 4;
  localparam int CODE_W  = 3;
  localparam int VEC_LSB = 1;
  localparam int CW      = (CH_N > 1) ? $clog2(CH_N) : 1;

  localparam logic [2:0] CMD_EXTRST = 3'b010;
  localparam logic [2:0] CMD_CHRST  = 3'b011;

  // cause index doubles as the low bits of the vector code
  localparam int C_TX   = 0;
  localparam int C_EXT  = 1;
  localparam int C_RX   = 2;
  localparam int C_SPEC = 3;

  localparam logic [CODE_W-1:0] CODE_IDLE = 3'b011;
endpackage

// File: rtl/ser_chan_regs.sv
module ser_chan_regs
  import sreg_pkg::*;
#(
  parameter bit HAS_VEC = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_wr,
  input  logic               ctl_rd,
  input  logic [DW-1:0]      wdata,
  input  logic               rx_avail,
  input  logic               tx_empty,
  input  logic [ERR_W-1:0]   rx_err,
  input  logic               cts,
  input  logic               dcd,
  input  logic               brk,
  input  logic               any_irq,
  input  logic [DW-1:0]      vec_in,
  output logic [DW-1:0]      rd_val,
  output logic [DW-1:0]      wr2,
  output logic [DW-1:0]      wr3,
  output logic [DW-1:0]      wr4,
  output logic [DW-1:0]      wr5,
  output logic               sav,
  output logic [CAUSE_N-1:0] pend
);
  logic [PTR_W-1:0] ptr;
  logic [DW-1:0]    wr1;
  logic             ext_pend;
  logic [2:0]       line_prev;
  logic [2:0]       line_now;
  logic             at_wr0, chrst, extclr, line_chg;

  assign at_wr0   = ctl_wr && (ptr == '0);
  assign chrst    = at_wr0 && (wdata[5:3] == CMD_CHRST);
  assign extclr   = at_wr0 && (wdata[5:3] == CMD_EXTRST);
  assign line_now = {brk, cts, dcd};
  assign line_chg = (line_now != line_prev);

  always_ff @(posedge clk) begin
    if (!rst_n || chrst) begin
      ptr <= '0;
      wr1 <= '0;
      wr2 <= '0;
      wr3 <= '0;
      wr4 <= '0;
      wr5 <= '0;
    end else if (at_wr0) begin
      ptr <= wdata[PTR_W-1:0];
    end else if (ctl_wr) begin
      ptr <= '0;
      case (ptr)
        3'd1: wr1 <= wdata;
        3'd2: if (HAS_VEC) wr2 <= wdata;
        3'd3: wr3 <= wdata;
        3'd4: wr4 <= wdata;
        3'd5: wr5 <= wdata;
        default: ;
      endcase
    end else if (ctl_rd) begin
      ptr <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) line_prev <= '0;
    else        line_prev <= line_now;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || chrst || extclr) ext_pend <= 1'b0;
    else if (wr1[0] && line_chg)   ext_pend <= 1'b1;
  end

  logic rx_mode_on;
  assign rx_mode_on   = (wr1[4:3] != 2'b00);
  assign pend[C_SPEC] = rx_mode_on && (|rx_err);
  assign pend[C_RX]   = rx_mode_on && rx_avail;
  assign pend[C_EXT]  = ext_pend;
  assign pend[C_TX]   = wr1[1] && tx_empty;
  assign sav          = wr1[2];

  always_comb begin
    rd_val = '0;
    case (ptr)
      3'd0: rd_val = {brk, 1'b0, cts, 1'b0, dcd, tx_empty, any_irq, rx_avail};
      3'd1: rd_val = {1'b0, rx_err, 4'b0000};
      3'd2: rd_val = HAS_VEC ? vec_in : '0;
      default: rd_val = '0;
    endcase
  end

  logic unused_bits;
  assign unused_bits = ^{wr1[7:5], vec_in};

  // R2
  ptr_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctl_wr || ctl_rd) && ptr != '0) |=> (ptr == '0));
  // R4
  chan_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chrst |=> (wr1 == '0 && wr3 == '0 && wr5 == '0 && !ext_pend && ptr == '0));
  // R8
  ext_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    extclr |=> !ext_pend);
  // R8
  ext_set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_pend) |-> ($past(wr1[0]) && $past(line_chg)));
endmodule

// File: rtl/ser_irq_arb.sv
module ser_irq_arb
  import sreg_pkg::*;
(
  input  logic [CAUSE_N-1:0] pend [CH_N],
  input  logic [DW-1:0]      base,
  input  logic               sav,
  output logic [DW-1:0]      vec,
  output logic               req
);
  logic [CODE_W-1:0] code;
  logic              found;

  always_comb begin
    found = 1'b0;
    code  = CODE_IDLE;
    for (int c = 0; c < CH_N; c++) begin
      for (int k = CAUSE_N - 1; k >= 0; k--) begin
        if (!found && pend[c][k]) begin
          found = 1'b1;
          code  = {(c == 0), k[1:0]};
        end
      end
    end
  end

  assign req = found;

  always_comb begin
    vec = base;
    if (sav) vec[VEC_LSB +: CODE_W] = code;
  end
endmodule

// File: rtl/ser_regif_top.sv
module ser_regif_top
  import sreg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ch_sel,
  input  logic                  ctl_sel,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic                  int_ack,
  input  logic [DW-1:0]         wdata,
  output logic [DW-1:0]         rdata,
  output logic                  int_req,
  output logic [DW-1:0]         tx_byte,
  output logic [CH_N-1:0]       tx_load,
  input  logic [CH_N*DW-1:0]    rx_byte,
  output logic [CH_N-1:0]       rx_take,
  input  logic [CH_N-1:0]       rx_avail,
  input  logic [CH_N-1:0]       tx_empty,
  input  logic [CH_N*ERR_W-1:0] rx_err,
  input  logic [CH_N-1:0]       cts,
  input  logic [CH_N-1:0]       dcd,
  input  logic [CH_N-1:0]       brk,
  output logic [CH_N-1:0]       rx_go,
  output logic [CH_N-1:0]       tx_go,
  output logic [CH_N-1:0]       rts,
  output logic [CH_N-1:0]       dtr,
  output logic [2*CH_N-1:0]     rx_len,
  output logic [2*CH_N-1:0]     tx_len,
  output logic [CH_N*DW-1:0]    fmt
);
  logic [DW-1:0]      rd_val [CH_N];
  logic [DW-1:0]      wr2    [CH_N];
  logic [DW-1:0]      wr3    [CH_N];
  logic [DW-1:0]      wr4    [CH_N];
  logic [DW-1:0]      wr5    [CH_N];
  logic               sav    [CH_N];
  logic [CAUSE_N-1:0] pend   [CH_N];
  logic [DW-1:0]      vec;
  logic               bus_live;

  assign bus_live = !int_ack;
  assign tx_byte  = wdata;

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    logic hit, auto_on;
    assign hit = bus_live && (ch_sel == CW'(c));

    ser_chan_regs #(.HAS_VEC(c == CH_N - 1)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_wr   (hit && ctl_sel && wr_en),
      .ctl_rd   (hit && ctl_sel && rd_en),
      .wdata    (wdata),
      .rx_avail (rx_avail[c]),
      .tx_empty (tx_empty[c]),
      .rx_err   (rx_err[c*ERR_W +: ERR_W]),
      .cts      (cts[c]),
      .dcd      (dcd[c]),
      .brk      (brk[c]),
      .any_irq  ((c == 0) ? int_req : 1'b0),
      .vec_in   (vec),
      .rd_val   (rd_val[c]),
      .wr2      (wr2[c]),
      .wr3      (wr3[c]),
      .wr4      (wr4[c]),
      .wr5      (wr5[c]),
      .sav      (sav[c]),
      .pend     (pend[c])
    );

    assign tx_load[c]       = hit && !ctl_sel && wr_en;
    assign rx_take[c]       = hit && !ctl_sel && rd_en;
    assign auto_on          = wr3[c][5];
    assign rx_go[c]         = wr3[c][0] && (!auto_on || dcd[c]);
    assign tx_go[c]         = wr5[c][3] && (!auto_on || cts[c]);
    assign rts[c]           = wr5[c][1];
    assign dtr[c]           = wr5[c][7];
    assign rx_len[2*c +: 2] = wr3[c][7:6];
    assign tx_len[2*c +: 2] = wr5[c][6:5];
    assign fmt[c*DW +: DW]  = wr4[c];

    logic unused_cfg;
    assign unused_cfg = ^{wr3[c][4:1], wr5[c][4], wr5[c][2], wr5[c][0]};
  end

  ser_irq_arb u_arb (
    .pend (pend),
    .base (wr2[CH_N-1]),
    .sav  (sav[CH_N-1]),
    .vec  (vec),
    .req  (int_req)
  );

  always_comb begin
    rdata = '0;
    if (int_ack)     rdata = vec;
    else if (rd_en)  rdata = ctl_sel ? rd_val[ch_sel] : rx_byte[ch_sel*DW +: DW];
  end

  logic unused_a;
  assign unused_a = ^{wr2[0], sav[0]};
endmodule

// File: tb/tb_ser_regif_top.sv
module tb_ser_regif_top;
  logic clk = 0;
  logic rst_n = 0;
  logic ch_sel = 0, ctl_sel = 0, wr_en = 0, rd_en = 0, int_ack = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic int_req;
  logic [7:0] tx_byte;
  logic [1:0] tx_load, rx_take;
  logic [15:0] rx_byte = 0;
  logic [1:0] rx_avail = 0, tx_empty = 0, cts = 0, dcd = 0, brk = 0;
  logic [5:0] rx_err = 0;
  logic [1:0] rx_go, tx_go, rts, dtr;
  logic [3:0] rx_len, tx_len;
  logic [15:0] fmt;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  ser_regif_top dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic ch, input logic ctl, input logic [7:0] d);
    @(negedge clk);
    ch_sel = ch; ctl_sel = ctl; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic bus_rd(input logic ch, input logic ctl, output logic [7:0] d);
    @(negedge clk);
    ch_sel = ch; ctl_sel = ctl; rd_en = 1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic wreg(input logic ch, input logic [2:0] r, input logic [7:0] v);
    if (r != 0) bus_wr(ch, 1'b1, {5'b0, r});
    bus_wr(ch, 1'b1, v);
  endtask

  task automatic rreg(input logic ch, input logic [2:0] r, output logic [7:0] v);
    if (r != 0) bus_wr(ch, 1'b1, {5'b0, r});
    bus_rd(ch, 1'b1, v);
  endtask

  task automatic ack(output logic [7:0] v);
    @(negedge clk);
    int_ack = 1;
    #1 v = rdata;
    @(negedge clk);
    int_ack = 0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 int_req", int_req, 0);
    chk("R1 tx_go/rx_go", {tx_go, rx_go}, 0);
    chk("R1 rts/dtr", {rts, dtr}, 0);
    chk("R1 fmt/len", {fmt, rx_len, tx_len}, 0);
    rreg(0, 0, v);
    chk("R1 rr0", v, 0);
  endtask

  task automatic t_pointer;
    wreg(1, 5, 8'hCA);
    chk("R5 dtr", dtr, 2'b10);
    chk("R5 rts", rts, 2'b10);
    chk("R5 tx_go", tx_go, 2'b10);
    chk("R5 tx_len", tx_len, 4'b1000);
    bus_wr(1, 1, 8'h04);
    bus_wr(1, 1, 8'h5A);
    chk("R2 ptr back to 0, wr4 reached", fmt, 16'h5A00);
    chk("R2 wr5 untouched", tx_go, 2'b10);
  endtask

  task automatic t_rx;
    wreg(1, 3, 8'hC1);
    chk("R6 rx_go", rx_go, 2'b10);
    chk("R6 rx_len", rx_len, 4'b1100);
    wreg(1, 3, 8'hE1);
    chk("R6 auto blocks rx without dcd", rx_go, 2'b00);
    chk("R5 auto blocks tx without cts", tx_go, 2'b00);
    @(negedge clk); dcd[1] = 1; cts[1] = 1;
    #1;
    chk("R6 auto with dcd", rx_go, 2'b10);
    chk("R5 auto with cts", tx_go, 2'b10);
  endtask

  task automatic t_absent;
    logic [7:0] v;
    wreg(0, 2, 8'h55);
    rreg(0, 2, v);
    chk("R3 chA rr2 reads 0", v, 0);
    wreg(0, 6, 8'hFF);
    wreg(0, 7, 8'hFF);
    chk("R3 wr6/wr7 no effect", {rts[0], dtr[0], tx_go[0], rx_go[0], fmt[7:0]}, 0);
    wreg(0, 5, 8'h08);
    chk("R3 ptr returned after absent", tx_go[0], 1);
  endtask

  task automatic t_status;
    logic [7:0] v;
    @(negedge clk);
    rx_avail[0] = 1; tx_empty[0] = 1; dcd[0] = 1; cts[0] = 1; brk[0] = 1; rx_err[2:0] = 3'b101;
    rreg(0, 0, v);
    chk("R7 rr0", v, 8'hAD);
    rreg(0, 1, v);
    chk("R7 rr1", v, 8'h50);
    @(negedge clk);
    rx_avail[0] = 0; tx_empty[0] = 0; dcd[0] = 0; cts[0] = 0; brk[0] = 0; rx_err[2:0] = 0;
    @(negedge clk);
  endtask

  task automatic t_ext;
    logic [7:0] v;
    wreg(0, 1, 8'h01);
    chk("R8 no latch without change", int_req, 0);
    @(negedge clk); cts[0] = 1;
    @(negedge clk);
    chk("R8 latch on cts change", int_req, 1);
    rreg(0, 0, v);
    chk("R7 rr0 int pending bit", v, 8'h22);
    bus_wr(0, 1, 8'h10);
    chk("R8 cleared by command", int_req, 0);
    wreg(0, 1, 8'h00);
    @(negedge clk); brk[0] = 1;
    @(negedge clk); @(negedge clk);
    chk("R8 disabled ignores change", int_req, 0);
    brk[0] = 0; cts[0] = 0;
    @(negedge clk);
  endtask

  task automatic t_vector;
    logic [7:0] v;
    wreg(1, 2, 8'h40);
    wreg(0, 1, 8'h1B);
    wreg(1, 1, 8'h1E);
    ack(v); chk("R10 idle code", v, 8'h46);
    chk("R9 no request", int_req, 0);
    tx_empty[1] = 1; ack(v); chk("R11 B tx", v, 8'h40);
    chk("R9 request", int_req, 1);
    rx_avail[1] = 1; ack(v); chk("R11 B rx", v, 8'h44);
    rx_err[3] = 1;   ack(v); chk("R11 B special", v, 8'h46);
    tx_empty[0] = 1; ack(v); chk("R11 A tx over B", v, 8'h48);
    rx_avail[0] = 1; ack(v); chk("R11 A rx", v, 8'h4C);
    rx_err[0] = 1;   ack(v); chk("R11 A special", v, 8'h4E);
    rx_err[0] = 0; rx_avail[0] = 0; ack(v); chk("R11 back to A tx", v, 8'h48);
    @(negedge clk); cts[0] = 1;
    @(negedge clk);
    ack(v); chk("R11 A ext over A tx", v, 8'h4A);
    bus_wr(0, 1, 8'h10);
    ack(v); chk("R8 ext cleared in vector", v, 8'h48);
    wreg(1, 1, 8'h1A);
    ack(v); chk("R10 sav off gives base", v, 8'h40);
    @(negedge clk);
    tx_empty = 0; rx_avail = 0; rx_err = 0;
    wreg(0, 1, 8'h00);
    wreg(1, 1, 8'h00);
    @(negedge clk); rx_avail[0] = 1;
    #1 chk("R9 rx mode 0 no request", int_req, 0);
    @(negedge clk); rx_avail[0] = 0;
  endtask

  task automatic t_ack_ptr;
    logic [7:0] v;
    bus_wr(1, 1, 8'h05);
    ack(v);
    chk("R12 ack returns vector", v, 8'h40);
    bus_wr(1, 1, 8'h02);
    chk("R12 ptr kept across ack", {rts[1], dtr[1], tx_go[1]}, 3'b100);
  endtask

  task automatic t_chreset;
    logic [7:0] v;
    bus_wr(0, 1, 8'h18);
    chk("R4 A cleared", {tx_go[0], rts[0], dtr[0]}, 0);
    chk("R4 B kept", rts[1], 1);
    ack(v);
    chk("R4 B vector base kept", v, 8'h40);
  endtask

  task automatic t_data;
    logic [7:0] v;
    @(negedge clk);
    ch_sel = 0; ctl_sel = 0; wdata = 8'h5A; wr_en = 1;
    #1 chk("R13 tx_load", tx_load, 2'b01);
    chk("R13 tx_byte", tx_byte, 8'h5A);
    @(negedge clk); wr_en = 0;
    rx_byte = 16'h3CC3;
    @(negedge clk);
    ch_sel = 1; rd_en = 1;
    #1 v = rdata;
    chk("R13 rx_take", rx_take, 2'b10);
    chk("R13 rx byte B", v, 8'h3C);
    @(negedge clk); rd_en = 0;
    @(negedge clk); int_ack = 1; ch_sel = 0; wr_en = 1;
    #1 chk("R12 data path blocked in ack", tx_load, 2'b00);
    @(negedge clk); int_ack = 0; wr_en = 0;
  endtask

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_pointer;
    t_rx;
    t_absent;
    t_status;
    t_ext;
    t_vector;
    t_ack_ptr;
    t_chreset;
    t_data;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule